// File: doc/BRIEF.md
# Pulse-Width Accumulating Cell Counter

This block is the digital half of one processing cell in a time-domain weighted-sum array. An analog comparator compares a shared voltage ramp with either the cell input or a shared minimum reference. While the ramp is enabled and the comparator output is high, the cell emits a pulse whose width is proportional to the compared voltage. The block uses that pulse, or a neighbour's pulse, or the difference between its own pulse and a neighbour's pulse, to gate a measurement clock. A signed up/down counter accumulates the gated clock edges. Each term's weight comes from the measurement clock frequency, which the controller sets before each ramp.

Fixed comparator offset and timing skew cancel when a ramp against the reference is counted in the opposite direction to a ramp against the input. The controller clears the counter before a computation. After all terms have been accumulated, the counter holds a signed 8-bit result. The counter saturates instead of wrapping, and a sticky flag records that saturation occurred. The comparator, the ramp generator and the frequency synthesis are outside this block.

Top module: `pwc_cell_counter`

## Requirements
- R1: The cell's own pulse is high only while `ramp_en` and `comp_out` are both high. A high comparator output while `ramp_en` is low never moves the counter.
- R2: The counter changes by exactly one on each rising `clk` edge at which the gating signal is high. It holds its value on every other edge.
- R3: Outside differential mode, the count direction is `up` XOR `ref_phase`. A value of 1 increments and 0 decrements.
- R4: Count a reference ramp with `ref_phase`=1 and an input ramp with `ref_phase`=0, both with `up`=1. The net change is the input pulse width minus the reference pulse width, in clock cycles. With `up`=0 the net change is the negative of that.
- R5: `nbr_sel`=0 selects the own pulse. `nbr_sel`=k for 1..NBR selects `nbr_pulse[k-1]`. Larger codes select a constant low pulse. Outside differential mode, the selected pulse alone gates the clock.
- R6: With `diff_mode`=1, the gating signal is high only while the own pulse and the selected pulse differ.
- R7: With `diff_mode`=1, while the own pulse is low and the selected pulse is high, the direction from R3 is inverted.
- R8: A synchronous `clr` clears the count to 0 and the overflow flag to 0. It overrides any counting in the same cycle.
- R9: The count is two's complement with CNT_W=8 bits, so its limits are -128 and 127. A step past either limit leaves the count at that limit.
- R10: `ovf` becomes 1 on the edge at which a step is blocked by a limit. It then stays 1 until `clr`.
- R11: `nbr_sel` changes only while `ramp_en` is low. A new selection takes effect on the next ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock, the rising edge counts |
| clr | input | 1 | Synchronous clear of count and flag |
| ramp_en | input | 1 | High while the shared ramp is running |
| comp_out | input | 1 | Comparator output of this cell |
| nbr_pulse | input | NBR | Pulses formed by neighbouring cells |
| nbr_sel | input | SELW | Source select: 0 own, k neighbour k-1 |
| diff_mode | input | 1 | 1 gates with own XOR selected pulse |
| up | input | 1 | Sign of the current term |
| ref_phase | input | 1 | 1 while the comparator sees the reference |
| count | output | CNT_W | Signed accumulated result |
| ovf | output | 1 | Sticky saturation flag |

## Verification
The hardest situation to reach is saturation followed by counting in the other direction. Getting there requires many ramps of the same sign to pile up beyond 127 without an intervening clear. The stimulus then reverses the sign to show that the flag stays set while the count leaves the limit. The bench drives a long series of full-width positive ramps followed by a single down ramp, and does the mirror image at -128. The differential inversion of R7 is reached only when the neighbour pulse outlasts the own pulse, so the bench sweeps every pair of pulse widths on a small ramp.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  typedef enum logic {
    MODE_TDM  = 1'b0,
    MODE_DIFF = 1'b1
  } gate_mode_e;

  // Base direction: reference ramps count against the term sign.
  function automatic logic base_dir(input logic up_i, input logic ref_i);
    return up_i ^ ref_i;
  endfunction

  // Differential inversion: the neighbour pulse outlasts the own pulse.
  function automatic logic diff_flip(input logic own_i, input logic other_i);
    return (!own_i) && other_i;
  endfunction

endpackage

// File: rtl/pwc_pulse_former.sv
module pwc_pulse_former (
  input  logic ramp_en,
  input  logic comp_out,
  output logic pulse
);
  // Comparator is meaningful only while the ramp runs.
  assign pulse = ramp_en & comp_out;
endmodule

// File: rtl/pwc_gate_logic.sv
module pwc_gate_logic #(
  parameter int NBR  = 4,
  parameter int SELW = $clog2(NBR + 1)
) (
  input  logic            own_pulse,
  input  logic [NBR-1:0]  nbr_pulse,
  input  logic [SELW-1:0] nbr_sel,
  input  logic            diff_mode,
  input  logic            up,
  input  logic            ref_phase,
  output logic            sel_pulse,
  output logic            gate,
  output logic            dir
);
  import pwc_pkg::*;

  localparam int NSRC = NBR + 1;

  logic [NSRC-1:0] src;
  logic [NSRC-1:0] hit;
  gate_mode_e      mode;

  assign src  = {nbr_pulse, own_pulse};
  assign mode = gate_mode_e'(diff_mode);

  // One-hot match per source; codes above NBR match nothing.
  for (genvar k = 0; k < NSRC; k++) begin : g_src
    assign hit[k] = (nbr_sel == SELW'(k)) & src[k];
  end

  assign sel_pulse = |hit;

  always_comb begin
    if (mode == MODE_DIFF) begin
      gate = own_pulse ^ sel_pulse;
      dir  = base_dir(up, ref_phase) ^ diff_flip(own_pulse, sel_pulse);
    end else begin
      gate = sel_pulse;
      dir  = base_dir(up, ref_phase);
    end
  end
endmodule

// File: rtl/pwc_sat_counter.sv
module pwc_sat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             step_en,
  input  logic             step_up,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CMAX = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] CMIN = {1'b1, {(CNT_W-1){1'b0}}};

  // Returns {blocked_by_limit, next_value}.
  function automatic logic [CNT_W:0] sat_step(input logic [CNT_W-1:0] cur,
                                             input logic go_up);
    logic             blocked;
    logic [CNT_W-1:0] nxt;
    if (go_up) begin
      blocked = (cur == CMAX);
      nxt     = blocked ? cur : cur + CNT_W'(1);
    end else begin
      blocked = (cur == CMIN);
      nxt     = blocked ? cur : cur - CNT_W'(1);
    end
    return {blocked, nxt};
  endfunction

  logic [CNT_W-1:0] count_q;
  logic             ovf_q;
  logic [CNT_W-1:0] nxt_val;
  logic             sat_hit;

  always_comb {sat_hit, nxt_val} = sat_step(count_q, step_up);

  always_ff @(posedge clk) begin
    if (clr) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else if (step_en) begin
      count_q <= nxt_val;
      if (sat_hit) ovf_q <= 1'b1;
    end
  end

  assign count = count_q;
  assign ovf   = ovf_q;

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (clr)
    !step_en |=> $stable(count_q)); // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (clr)
    (step_en && step_up && count_q != CMAX) |=> count_q == $past(count_q) + CNT_W'(1)); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (clr)
    (step_en && !step_up && count_q != CMIN) |=> count_q == $past(count_q) - CNT_W'(1)); // R3
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (clr)
    (step_en && step_up && count_q == CMAX) |=> (count_q == CMAX && ovf_q)); // R9
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (clr)
    (step_en && !step_up && count_q == CMIN) |=> (count_q == CMIN && ovf_q)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (clr)
    ovf_q |=> ovf_q); // R10
endmodule

// File: rtl/pwc_cell_counter.sv
module pwc_cell_counter #(
  parameter int CNT_W = 8,
  parameter int NBR   = 4,
  parameter int SELW  = $clog2(NBR + 1)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             ramp_en,
  input  logic             comp_out,
  input  logic [NBR-1:0]   nbr_pulse,
  input  logic [SELW-1:0]  nbr_sel,
  input  logic             diff_mode,
  input  logic             up,
  input  logic             ref_phase,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  // Named internal events, visible to the assertions.
  logic own_pulse;
  logic sel_pulse;
  logic gate;
  logic dir;

  pwc_pulse_former u_pulse (
    .ramp_en  (ramp_en),
    .comp_out (comp_out),
    .pulse    (own_pulse)
  );

  pwc_gate_logic #(.NBR(NBR), .SELW(SELW)) u_gate (
    .own_pulse (own_pulse),
    .nbr_pulse (nbr_pulse),
    .nbr_sel   (nbr_sel),
    .diff_mode (diff_mode),
    .up        (up),
    .ref_phase (ref_phase),
    .sel_pulse (sel_pulse),
    .gate      (gate),
    .dir       (dir)
  );

  pwc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .clr     (clr),
    .step_en (gate),
    .step_up (dir),
    .count   (count),
    .ovf     (ovf)
  );

  AST_NO_COUNT_WITHOUT_RAMP: assert property (@(posedge clk) disable iff (clr)
    (!ramp_en && nbr_sel == '0 && !diff_mode) |=> $stable(count)); // R1
  AST_DIFF_EQUAL_HOLD: assert property (@(posedge clk) disable iff (clr)
    (diff_mode && own_pulse == sel_pulse) |=> $stable(count)); // R6
  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (clr)
    (ramp_en && $past(ramp_en)) |-> $stable(nbr_sel)); // R11
endmodule

// File: tb/pwc_cell_counter_tb_top.sv
module pwc_cell_counter_tb_top;
  localparam int CLK_P = 10;
  localparam int CNT_W = 8;
  localparam int NBR   = 4;
  localparam int SELW  = 3;
  localparam int L     = 12;   // ramp length in clock cycles

  logic             clk = 1'b0;
  logic             clr = 1'b1;
  logic             ramp_en = 1'b0;
  logic             comp_out = 1'b0;
  logic [NBR-1:0]   nbr_pulse = '0;
  logic [SELW-1:0]  nbr_sel = '0;
  logic             diff_mode = 1'b0;
  logic             up = 1'b1;
  logic             ref_phase = 1'b0;
  logic [CNT_W-1:0] count;
  logic             ovf;

  int n_chk = 0;
  int n_fail = 0;
  int exp_cnt = 0;
  bit exp_ovf = 1'b0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  pwc_cell_counter #(.CNT_W(CNT_W), .NBR(NBR), .SELW(SELW)) dut_i (
    .clk(clk), .clr(clr), .ramp_en(ramp_en), .comp_out(comp_out),
    .nbr_pulse(nbr_pulse), .nbr_sel(nbr_sel), .diff_mode(diff_mode),
    .up(up), .ref_phase(ref_phase), .count(count), .ovf(ovf)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " count"}, int'($signed(count)), exp_cnt);
    chk({req, " ovf"}, int'(ovf), int'(exp_ovf));
  endtask

  // Independent model of one gated edge with saturation.
  task automatic model_edge(input bit g, input bit d);
    if (g) begin
      if (d) begin
        if (exp_cnt >= 127) exp_ovf = 1'b1; else exp_cnt = exp_cnt + 1;
      end else begin
        if (exp_cnt <= -128) exp_ovf = 1'b1; else exp_cnt = exp_cnt - 1;
      end
    end
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    exp_cnt = 0; exp_ovf = 1'b0;
  endtask

  // One ramp of L cycles: own pulse ow cycles long, neighbour ni pulse nw
  // cycles long, every other neighbour high for the whole ramp.
  task automatic run_ramp(input int ow, input int nw, input int ni, input int sl,
                          input bit rp, input bit u, input bit dm);
    bit own, sp, g, d;
    for (int i = 0; i < L; i++) begin
      @(negedge clk);
      nbr_sel = SELW'(sl); ref_phase = rp; up = u; diff_mode = dm;
      ramp_en = 1'b1;
      comp_out = (i < ow);
      for (int k = 0; k < NBR; k++) nbr_pulse[k] = (k == ni) ? (i < nw) : 1'b1;
      own = (i < ow);
      if (sl == 0) sp = own;
      else if (sl <= NBR) sp = ((sl - 1) == ni) ? (i < nw) : 1'b1;
      else sp = 1'b0;
      if (dm) begin
        g = own ^ sp;
        d = (u ^ rp) ^ (!own && sp);
      end else begin
        g = sp;
        d = u ^ rp;
      end
      model_edge(g, d);
    end
    @(negedge clk);
    ramp_en = 1'b0; comp_out = 1'b0; nbr_pulse = '0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    clr = 1'b0;
    chk_state("R8 reset");

    // R1: comparator high without ramp enable does nothing
    @(negedge clk); nbr_sel = '0; diff_mode = 1'b0; up = 1'b1; ref_phase = 1'b0;
    comp_out = 1'b1; ramp_en = 1'b0;
    repeat (5) @(negedge clk);
    comp_out = 1'b0;
    chk_state("R1 comp without ramp");
    run_ramp(0, 0, 0, 0, 1'b0, 1'b1, 1'b0);
    chk_state("R1 ramp without comp");

    // R2/R3: own-pulse widths under every direction combination
    for (int c = 0; c < 4; c++) begin
      for (int w = 0; w <= L; w++) begin
        do_clr();
        run_ramp(w, 0, 0, 0, c[1], c[0], 1'b0);
        chk_state("R2 R3 width sweep");
      end
    end

    // R4: reference ramp then input ramp
    for (int m = 1; m <= 4; m += 3) begin
      for (int v = 0; v <= L; v++) begin
        do_clr();
        run_ramp(m, 0, 0, 0, 1'b1, 1'b1, 1'b0);
        run_ramp(v, 0, 0, 0, 1'b0, 1'b1, 1'b0);
        chk("R4 net plus", int'($signed(count)), v - m);
        do_clr();
        run_ramp(m, 0, 0, 0, 1'b1, 1'b0, 1'b0);
        run_ramp(v, 0, 0, 0, 1'b0, 1'b0, 1'b0);
        chk("R4 net minus", int'($signed(count)), m - v);
      end
    end

    // R5/R11: every select code, selection changed between ramps
    for (int s = 0; s < 8; s++) begin
      do_clr();
      run_ramp(7, 3, (s == 0) ? 0 : s - 1, s, 1'b0, 1'b1, 1'b0);
      chk_state("R5 R11 select");
    end

    // R6/R7: differential over every width pair and direction
    for (int u = 0; u < 2; u++) begin
      for (int a = 0; a <= L; a++) begin
        for (int b = 0; b <= L; b++) begin
          do_clr();
          run_ramp(a, b, 1, 2, 1'b0, u[0], 1'b1);
          chk_state("R6 R7 differential");
          chk("R7 signed difference", int'($signed(count)), u[0] ? (a - b) : (b - a));
        end
      end
    end

    // R9/R10: saturation high, then leave the limit
    do_clr();
    for (int r = 0; r < 12; r++) run_ramp(L, 0, 0, 0, 1'b0, 1'b1, 1'b0);
    chk_state("R9 saturate high");
    chk("R9 high limit", int'($signed(count)), 127);
    run_ramp(L, 0, 0, 0, 1'b0, 1'b0, 1'b0);
    chk_state("R10 sticky after high");
    chk("R10 flag kept", int'(ovf), 1);

    do_clr();
    chk_state("R8 clear after ovf");
    for (int r = 0; r < 12; r++) run_ramp(L, 0, 0, 0, 1'b1, 1'b1, 1'b0);
    chk_state("R9 saturate low");
    chk("R9 low limit", int'($signed(count)), -128);
    run_ramp(3, 0, 0, 0, 1'b0, 1'b1, 1'b0);
    chk_state("R10 sticky after low");

    // R8: clear wins over an active gate
    @(negedge clk); nbr_sel = '0; diff_mode = 1'b0; up = 1'b1; ref_phase = 1'b0;
    ramp_en = 1'b1; comp_out = 1'b1; clr = 1'b1;
    repeat (3) @(negedge clk);
    exp_cnt = 0; exp_ovf = 1'b0;
    chk_state("R8 clear priority");
    clr = 1'b0; ramp_en = 1'b0; comp_out = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule